// File: doc/BRIEF.md
# Serial Receive Byte Buffer and Frame Status Unit

This unit sits between a serial frame receiver and a CPU. Each whole byte the line side assembles enters a small first-in first-out buffer. The CPU reads the bytes back oldest first. At every frame boundary the unit records an 8-bit status word. That word reports a clean finish, a CRC failure, a misaligned end, an abort or collision, and a buffer overrun. It also shows whether the buffer holds data, and it carries the two control bits that software writes: receive enable and acknowledge enable.

Software turns reception on by writing the receive-enable bit. That write empties the buffer and clears the frame outcome flags from the previous frame. The hardware drops receive enable when a frame ends, on an error, or on an overrun. The line mode input selects between two rule sets, a contention (CSMA/CD) link and a flag-delimited (SDLC) link. The two modes differ in how a partial byte at end of frame is judged and in whether collisions count. The not-empty flag follows a buffer read only after a fixed delay.

Top module: `rx_fifo_stat`

## Requirements
- R1: After reset, `stat` is 0x00 and `rd_data` is 0x00.
- R2: The buffer holds DEPTH (3) bytes. A read pulse with data present returns the oldest byte on `rd_data` one cycle later. `rd_data` holds its value between reads.
- R3: A byte that arrives while the buffer is full, with no read in the same cycle, is dropped. It sets overrun (stat bit 7) and clears receive enable (bit 1). A read pulse on an empty buffer leaves `rd_data` and the buffer unchanged.
- R4: A CPU write stores `wr_data` bit 1 as receive enable and bit 0 as acknowledge enable (stat bit 0). If bit 1 is 1, the write empties the buffer and clears stat bits 7..2. In a write cycle, the line strobes are ignored.
- R5: Bytes are stored only while receive enable is 1.
- R6: Stat bit 2 (not-empty) follows the buffer occupancy with a lag of one cycle. After a read that takes a byte, it stays frozen for NE_DELAY (12) cycles and then takes the new value. Each later read restarts that delay.
- R7: An end-of-frame strobe while enabled clears receive enable. It sets done (bit 3) only when neither CRC error (bit 4), alignment error (bit 5) nor overrun applies. CRC error is set for a byte-aligned frame (residual count 0) with a bad CRC.
- R8: With `ln_sdlc`=0 at end of frame, a nonzero residual count sets alignment error only if the CRC is bad. With a good CRC the leftover bits are discarded and the frame completes.
- R9: With `ln_sdlc`=1 at end of frame, a nonzero residual count always sets alignment error. A bad CRC sets CRC error in addition.
- R10: A collision strobe with `ln_sdlc`=0 sets bit 6 and clears receive enable, whatever the enable value, when a byte of the current frame was stored in an earlier cycle. Otherwise the strobe has no effect. An abort strobe while enabled does the same. Either one takes precedence over a simultaneous end of frame.
- R11: With the buffer full, a read and an incoming byte in the same cycle both take effect, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ln_byte_vld | input | 1 | One-cycle strobe: a received byte is ready |
| ln_byte | input | 8 | Received byte |
| ln_eof | input | 1 | One-cycle strobe: frame ended |
| ln_resid | input | 3 | Bits left in the shift register at end of frame |
| ln_crc_ok | input | 1 | CRC check passed, valid with ln_eof |
| ln_coll | input | 1 | Collision strobe |
| ln_abort | input | 1 | Abort strobe |
| ln_sdlc | input | 1 | 0: CSMA/CD rules, 1: SDLC rules |
| wr_en | input | 1 | CPU write of the control bits |
| wr_data | input | 8 | Write data; bit 1 receive enable, bit 0 acknowledge enable |
| rd_en | input | 1 | CPU read pulse for the buffer |
| rd_data | output | 8 | Last byte read from the buffer |
| stat | output | 8 | {overrun, abort/collision, align err, CRC err, done, not-empty, rx enable, ack enable} |

## Verification
Two pairs of events can land in the same cycle. The first is a buffer read and an incoming byte while the buffer is full; the bench drives both strobes on one clock and expects no overrun and an unbroken byte order. The second is an end-of-frame strobe and a collision or abort; the bench pairs them and expects only the abort flag, with done clear. A behavioural model built on a queue runs beside the design. Status and read data are compared on every clock, so a wrong precedence shows up in the cycle where it happens.

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat #(
  parameter int DEPTH    = 3,
  parameter int NE_DELAY = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ln_byte_vld,
  input  logic [7:0] ln_byte,
  input  logic       ln_eof,
  input  logic [2:0] ln_resid,
  input  logic       ln_crc_ok,
  input  logic       ln_coll,
  input  logic       ln_abort,
  input  logic       ln_sdlc,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic [7:0] stat
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HW = $clog2(NE_DELAY + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;
  logic ovf, cab, ae, crce, done, nef, rx_on, ack, frame;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire flush    = wr_en & wr_data[1];
  wire pop      = rd_en & (cnt != '0);
  wire line_ok  = ~wr_en;
  wire take     = line_ok & rx_on & ln_byte_vld;
  wire room     = (cnt != CW'(DEPTH)) | pop;
  wire push     = take & room;
  wire drop     = take & ~room;
  wire err      = line_ok & ((ln_abort & rx_on) | (ln_coll & ~ln_sdlc & frame));
  wire fin      = line_ok & ln_eof & rx_on & ~err;
  wire partial  = ln_resid != 3'd0;
  wire ae_now   = ln_sdlc ? partial : (partial & ~ln_crc_ok);
  wire crce_now = ln_sdlc ? ~ln_crc_ok : (~partial & ~ln_crc_ok);
  wire ovf_nx   = ovf | drop;

  assign stat = {ovf, cab, ae, crce, done, nef, rx_on, ack};

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= ln_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; rd_data <= 8'h00;
    end else begin
      if (pop) rd_data <= mem[rp];
      if (flush) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (push) wp <= nxt(wp);
        if (pop)  rp <= nxt(rp);
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ovf, cab, ae, crce, done, rx_on, ack, frame} <= '0;
    end else if (wr_en) begin
      rx_on <= wr_data[1];
      ack   <= wr_data[0];
      if (flush) {ovf, cab, ae, crce, done, frame} <= '0;
    end else begin
      if (drop) begin ovf <= 1'b1; rx_on <= 1'b0; end
      if (push) frame <= 1'b1;
      if (err) begin
        cab <= 1'b1; rx_on <= 1'b0; frame <= 1'b0;
      end else if (fin) begin
        ae    <= ae_now;
        crce  <= crce_now;
        done  <= ~ae_now & ~crce_now & ~ovf_nx;
        rx_on <= 1'b0;
        frame <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nef <= 1'b0; hold <= '0;
    end else if (flush) begin
      nef <= 1'b0; hold <= '0;
    end else if (pop) begin
      hold <= HW'(NE_DELAY - 1);
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
    end else begin
      nef <= (cnt != '0);
    end
  end
endmodule

// File: rtl/rx_fifo_stat_chk.sv
module rx_fifo_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ln_eof,
  input logic [2:0] ln_resid,
  input logic       ln_coll,
  input logic       ln_abort,
  input logic       ln_sdlc,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic [7:0] stat
);
  a_r4_enable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[1] |=> stat[7:2] == 6'd0 && stat[1]);

  a_r7_eof_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && ln_eof && stat[1] |=> !stat[1]);

  a_r7_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    stat[3] |-> !stat[4] && !stat[5]);

  a_r3_overrun_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[7]) |-> !stat[1]);

  a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  a_r9_sdlc_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && stat[1] && ln_eof && ln_sdlc && ln_resid != 3'd0 && !ln_abort |=> stat[5]);

  a_r10_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && stat[1] && ln_abort |=> stat[6] && !stat[1]);
endmodule

bind rx_fifo_stat rx_fifo_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ln_eof(ln_eof), .ln_resid(ln_resid),
  .ln_coll(ln_coll), .ln_abort(ln_abort), .ln_sdlc(ln_sdlc),
  .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_data(rd_data), .stat(stat)
);

// File: tb/rx_fifo_stat_bench.sv
module rx_fifo_stat_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ln_byte_vld = 0, ln_eof = 0, ln_crc_ok = 0, ln_coll = 0, ln_abort = 0, ln_sdlc = 0;
  logic [7:0] ln_byte = 0;
  logic [2:0] ln_resid = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, stat;

  always #10 clk = ~clk;

  rx_fifo_stat u_rx_fifo_stat (.*);

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference
  byte unsigned q[$];
  bit m_on, m_ack, m_ovf, m_cab, m_ae, m_crce, m_done, m_nef, m_frame;
  int m_hold, sz;
  bit pop, fr_old, on_old, er, part, a_n, c_n;
  logic [7:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      {m_on, m_ack, m_ovf, m_cab, m_ae, m_crce, m_done, m_nef, m_frame} = '0;
      m_hold = 0; m_data = 8'h00;
    end else begin
      sz  = q.size();
      pop = rd_en && sz > 0;
      if (pop) m_data = q.pop_front();
      if (wr_en) begin
        m_on = wr_data[1]; m_ack = wr_data[0];
        if (wr_data[1]) begin
          q.delete();
          {m_ovf, m_cab, m_ae, m_crce, m_done, m_frame, m_nef} = '0;
          m_hold = 0;
        end
      end else begin
        fr_old = m_frame; on_old = m_on;
        if (on_old && ln_byte_vld) begin
          if (q.size() < 3) begin q.push_back(ln_byte); m_frame = 1; end
          else begin m_ovf = 1; m_on = 0; end
        end
        er = (ln_abort && on_old) || (ln_coll && !ln_sdlc && fr_old);
        if (er) begin
          m_cab = 1; m_on = 0; m_frame = 0;
        end else if (ln_eof && on_old) begin
          part = ln_resid != 0;
          a_n  = ln_sdlc ? part : (part && !ln_crc_ok);
          c_n  = ln_sdlc ? !ln_crc_ok : (!part && !ln_crc_ok);
          m_ae = a_n; m_crce = c_n;
          m_done = !a_n && !c_n && !m_ovf;
          m_on = 0; m_frame = 0;
        end
      end
      if (!(wr_en && wr_data[1])) begin
        if (pop) m_hold = 11;
        else if (m_hold > 0) m_hold--;
        else m_nef = (sz != 0);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(stat == {m_ovf, m_cab, m_ae, m_crce, m_done, m_nef, m_on, m_ack},
            cur_req, stat, {m_ovf, m_cab, m_ae, m_crce, m_done, m_nef, m_on, m_ack});
      check(rd_data == m_data, cur_req, rd_data, m_data);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    {ln_byte_vld, ln_eof, ln_coll, ln_abort, wr_en, rd_en} = '0;
  endtask
  task automatic idle(input int n);
    repeat (n) step();
  endtask
  task automatic cpu_wr(input logic [7:0] v);
    wr_en = 1; wr_data = v; step();
  endtask
  task automatic rx_byte(input logic [7:0] b);
    ln_byte_vld = 1; ln_byte = b; step();
  endtask
  task automatic rx_eof(input logic [2:0] r, input bit ok);
    ln_eof = 1; ln_resid = r; ln_crc_ok = ok; step();
  endtask
  task automatic cpu_rd();
    rd_en = 1; step();
  endtask
  task automatic look(input bit ok, input string req, input int act, input int exp);
    @(negedge clk); check(ok, req, act, exp); @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    look(stat == 8'h00 && rd_data == 8'h00, "R1", stat, 0);

    cur_req = "R4";
    cpu_wr(8'h03);
    look(stat == 8'h03, "R4", stat, 8'h03);

    cur_req = "R3";
    rx_byte(8'hA1); rx_byte(8'hA2); rx_byte(8'hA3); rx_byte(8'hA4);
    look(stat[7] && !stat[1], "R3", stat, 8'h85);

    cur_req = "R2";
    cpu_rd(); look(rd_data == 8'hA1, "R2", rd_data, 8'hA1);
    cur_req = "R6";
    idle(3); look(stat[2] == 1'b1, "R6", stat[2], 1);
    cur_req = "R2";
    cpu_rd(); cpu_rd(); look(rd_data == 8'hA3, "R2", rd_data, 8'hA3);
    cur_req = "R3";
    cpu_rd(); look(rd_data == 8'hA3, "R3", rd_data, 8'hA3);
    cur_req = "R6";
    idle(14); look(stat[2] == 1'b0, "R6", stat[2], 0);

    cur_req = "R5";
    cpu_wr(8'h00); rx_byte(8'h55); idle(3);
    look(stat[2] == 1'b0, "R5", stat[2], 0);
    cpu_rd(); look(rd_data == 8'hA3, "R5", rd_data, 8'hA3);

    cur_req = "R4";
    cpu_wr(8'h02); rx_byte(8'h11); idle(2);
    cpu_wr(8'h02);
    look(stat == 8'h02, "R4", stat, 8'h02);

    cur_req = "R8";
    rx_byte(8'h21); rx_byte(8'h22); rx_eof(3'd3, 1);
    look(stat[3] && !stat[5] && !stat[1], "R8", stat, 8'h0C);

    cur_req = "R8";
    cpu_wr(8'h02); rx_byte(8'h31); rx_eof(3'd5, 0);
    look(stat[5] && !stat[4] && !stat[3], "R8", stat, 8'h24);

    cur_req = "R7";
    cpu_wr(8'h02); rx_byte(8'h41); rx_eof(3'd0, 0);
    look(stat[4] && !stat[5] && !stat[3] && !stat[1], "R7", stat, 8'h14);
    cpu_wr(8'h02); rx_byte(8'h42); rx_eof(3'd0, 1);
    look(stat[3] && !stat[4], "R7", stat, 8'h0C);

    cur_req = "R9";
    ln_sdlc = 1;
    cpu_wr(8'h02); rx_byte(8'h51); rx_eof(3'd2, 1);
    look(stat[5] && !stat[4] && !stat[3], "R9", stat, 8'h24);
    cpu_wr(8'h02); rx_byte(8'h52); rx_eof(3'd2, 0);
    look(stat[5] && stat[4], "R9", stat, 8'h34);
    cpu_wr(8'h02); rx_byte(8'h53); ln_coll = 1; step();
    look(!stat[6] && stat[1], "R10", stat, 8'h06);
    ln_sdlc = 0;

    cur_req = "R10";
    cpu_wr(8'h02); ln_coll = 1; step();
    look(!stat[6] && stat[1], "R10", stat, 8'h02);
    rx_byte(8'h61); cpu_wr(8'h00); ln_coll = 1; step();
    look(stat[6] && !stat[1], "R10", stat, 8'h44);
    cpu_wr(8'h02); rx_byte(8'h62); ln_abort = 1; ln_eof = 1; ln_resid = 0; ln_crc_ok = 1; step();
    look(stat[6] && !stat[3], "R10", stat, 8'h44);

    cur_req = "R11";
    cpu_wr(8'h02); rx_byte(8'h71); rx_byte(8'h72); rx_byte(8'h73);
    ln_byte_vld = 1; ln_byte = 8'h74; rd_en = 1; step();
    look(!stat[7] && stat[1] && rd_data == 8'h71, "R11", stat, 8'h06);
    cpu_rd(); look(rd_data == 8'h72, "R11", rd_data, 8'h72);
    cpu_rd(); cpu_rd(); look(rd_data == 8'h74, "R11", rd_data, 8'h74);
    idle(15);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule